// File: doc/BRIEF.md
# Multi-Bank Endpoint Packet Buffer Controller

This block holds the packet banks of one USB device endpoint and decides, cycle by cycle, which side owns each bank. One side fills the current fill bank byte by byte. For an IN endpoint that side is the firmware or DMA, and for an OUT endpoint it is the bus. The other side drains the oldest ready bank. Banks are used in strict rotation. Each bank keeps its own byte count, so the drain side always sees the true packet length, including zero-length packets.

With automatic validation switched on, the block hands banks over by itself. For IN, a bank is committed when it fills up, or when the DMA reports end of buffer while end-of-buffer handling is enabled. For OUT, a bank is released when its last byte is read, or on the same end-of-buffer event. Software strobes can still commit a partly filled or empty IN bank, or throw away the rest of an OUT bank. The DMA request is suppressed while a masking bit is set and any enabled interrupt source of the endpoint is active.

Top module: `ep_bank_ctrl`

## Requirements
- R1: After reset no bank is ready (`bank_rdy_o` = 0, `busy_o` = 0), both pointers are 0 and `ovf_o` is 0. The endpoint enable `ep_en_o` is 1 when `EP_INDEX` is 0 and 0 for any other index.
- R2: IN (`dir_in_i` = 1) with automatic validation: the write that brings the fill bank to `BANK_BYTES` bytes sets that bank's ready bit (bit i of `bank_rdy_o` is bank i) on the same clock edge, and the fill pointer moves to the next bank.
- R3: IN with automatic validation: a `dma_eob_i` strobe commits the fill bank only while `eob_en_i` is 1. With `eob_en_i` = 0 the strobe has no effect.
- R4: IN: `sw_commit_i` commits the fill bank whether it is partly filled or empty. `rd_len_o` then reports the stored byte count (0 for an empty bank), and `rd_data_o` presents the bytes in write order.
- R5: OUT (`dir_in_i` = 0) with automatic validation: a bank committed by `wr_end_i` is released on the edge that reads its last byte. `rd_rdy_o` drops and the drain pointer advances.
- R6: OUT with automatic validation and `eob_en_i` = 1: `dma_eob_i` releases the drain bank even if some of its bytes are still unread.
- R7: OUT: `sw_release_i` releases the drain bank and drops its unread bytes. The next ready bank is then presented with its own length and first byte.
- R8: When `ctrl_type_i` = 1, the automatic-validation enable has no effect. A full bank stays uncommitted and end-of-buffer strobes commit nothing.
- R9: `dma_req_o` is 0 whenever `intdis_dma_i` = 1 and some bit of `irq_src_i & irq_en_i` is 1. Otherwise it is 1 when the endpoint is enabled and, for IN, the fill bank is free or, for OUT, the drain bank is ready.
- R10: A write into a bank that is ready or already holds `BANK_BYTES` bytes is dropped. It raises `ovf_o` for exactly the following cycle and leaves all stored data and counts unchanged.
- R11: Banks are filled and drained in the order 0, 1, …, NUM_BANKS-1, 0. `busy_o` is the binary number of ready banks.
- R12: While `ep_en_o` = 0, writes, reads, commits, releases and DMA strobes have no effect and `dma_req_o` is 0. `en_wr_i` loads `en_val_i` into the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_wr_i | input | 1 | Load endpoint enable |
| en_val_i | input | 1 | Enable value to load |
| ep_en_o | output | 1 | Endpoint enabled |
| dir_in_i | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| ctrl_type_i | input | 1 | Endpoint is of control type |
| auto_val_i | input | 1 | Automatic validation enable |
| eob_en_i | input | 1 | Act on DMA end of buffer |
| intdis_dma_i | input | 1 | Active interrupts mask the DMA request |
| wr_en_i | input | 1 | Write one byte into the fill bank |
| wr_data_i | input | DATA_W | Byte to write |
| wr_end_i | input | 1 | OUT: bus packet complete, commit the fill bank |
| sw_commit_i | input | 1 | IN: software commit of the fill bank |
| sw_release_i | input | 1 | OUT: software release of the drain bank |
| rd_en_i | input | 1 | Read one byte from the drain bank |
| rd_data_o | output | DATA_W | Current byte of the drain bank |
| rd_len_o | output | CW | Byte count of the drain bank |
| rd_rdy_o | output | 1 | Drain bank holds a committed packet |
| bus_done_i | input | 1 | IN: packet sent, free the drain bank |
| dma_eob_i | input | 1 | DMA end-of-buffer strobe |
| irq_src_i | input | NUM_SRC | Endpoint interrupt sources |
| irq_en_i | input | NUM_SRC | Interrupt source enables |
| dma_req_o | output | 1 | DMA request |
| ovf_o | output | 1 | Rejected write, one-cycle pulse |
| bank_rdy_o | output | NUM_BANKS | Ready bit of each bank |
| fill_ptr_o | output | PW | Fill bank index |
| drain_ptr_o | output | PW | Drain bank index |
| busy_o | output | BW | Number of ready banks |

## Verification
The checker relies on a few things being true of the inputs. The handoff and ordering assertions assume pointers move only through commit and release, and they read `bank_rdy_o` at the pointer's old value, so the pointer must never exceed `NUM_BANKS-1`. The overflow assertion assumes `wr_en_i` is held for a full cycle, so it can trace each pulse back to a write. The bench meets these by driving every strobe for exactly one clock, with all changes made on the falling edge. It also gives each direction only the strobes meant for that direction. Configuration inputs change only between packets or right after a reset.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } ep_dir_e;

  localparam int MAX_BANKS = 3;
endpackage

// File: rtl/ep_bank_store.sv
module ep_bank_store #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int PW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CW = $clog2(BANK_BYTES + 1),
  localparam int IW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ok_i,
  input  logic [PW-1:0]     wr_bank_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_ok_i,
  input  logic              rel_i,
  input  logic [PW-1:0]     rd_bank_i,
  output logic [CW-1:0]     fill_cnt_o,
  output logic [CW-1:0]     drain_cnt_o,
  output logic [CW-1:0]     rd_idx_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [NUM_BANKS][BANK_BYTES];
  logic [CW-1:0]     cnt_q [NUM_BANKS];
  logic [CW-1:0]     rd_idx_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               cnt_q[b] <= '0;
      else if (rel_i && rd_bank_i == PW'(b))     cnt_q[b] <= '0;
      else if (wr_ok_i && wr_bank_i == PW'(b))   cnt_q[b] <= cnt_q[b] + 1'b1;
    end
  end

  // data array carries no reset
  always_ff @(posedge clk_i) begin
    if (wr_ok_i) mem_q[wr_bank_i][cnt_q[wr_bank_i][IW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_idx_q <= '0;
    else if (rel_i)   rd_idx_q <= '0;
    else if (rd_ok_i) rd_idx_q <= rd_idx_q + 1'b1;
  end

  assign fill_cnt_o  = cnt_q[wr_bank_i];
  assign drain_cnt_o = cnt_q[rd_bank_i];
  assign rd_idx_o    = rd_idx_q;
  assign rd_data_o   = mem_q[rd_bank_i][rd_idx_q[IW-1:0]];
endmodule

// File: rtl/ep_bank_flags.sv
module ep_bank_flags #(
  parameter int NUM_BANKS = 2,
  localparam int PW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 commit_i,
  input  logic                 release_i,
  output logic [NUM_BANKS-1:0] rdy_o,
  output logic [PW-1:0]        fill_ptr_o,
  output logic [PW-1:0]        drain_ptr_o
);
  logic [NUM_BANKS-1:0] rdy_q, rdy_d;
  logic [PW-1:0]        fill_q, drain_q;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(NUM_BANKS - 1)) ? '0 : p + 1'b1;
  endfunction

  // commit needs a free fill bank, release a ready drain bank: never the same bank
  always_comb begin
    rdy_d = rdy_q;
    if (commit_i)  rdy_d[fill_q]  = 1'b1;
    if (release_i) rdy_d[drain_q] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= '0;
      fill_q  <= '0;
      drain_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      if (commit_i)  fill_q  <= ptr_next(fill_q);
      if (release_i) drain_q <= ptr_next(drain_q);
    end
  end

  assign rdy_o       = rdy_q;
  assign fill_ptr_o  = fill_q;
  assign drain_ptr_o = drain_q;
endmodule

// File: rtl/ep_dma_gate.sv
module ep_dma_gate #(
  parameter int NUM_SRC = 4
) (
  input  logic               req_raw_i,
  input  logic               intdis_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               req_o
);
  logic irq_live;
  assign irq_live = |(src_i & en_i);
  assign req_o    = req_raw_i & ~(intdis_i & irq_live);
endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
  import ep_bank_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 8,
  parameter int DATA_W     = 8,
  parameter int NUM_SRC    = 4,
  parameter int EP_INDEX   = 0,
  localparam int PW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CW = $clog2(BANK_BYTES + 1),
  localparam int BW = $clog2(NUM_BANKS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_wr_i,
  input  logic                 en_val_i,
  output logic                 ep_en_o,
  input  logic                 dir_in_i,
  input  logic                 ctrl_type_i,
  input  logic                 auto_val_i,
  input  logic                 eob_en_i,
  input  logic                 intdis_dma_i,
  input  logic                 wr_en_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 wr_end_i,
  input  logic                 sw_commit_i,
  input  logic                 sw_release_i,
  input  logic                 rd_en_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [CW-1:0]        rd_len_o,
  output logic                 rd_rdy_o,
  input  logic                 bus_done_i,
  input  logic                 dma_eob_i,
  input  logic [NUM_SRC-1:0]   irq_src_i,
  input  logic [NUM_SRC-1:0]   irq_en_i,
  output logic                 dma_req_o,
  output logic                 ovf_o,
  output logic [NUM_BANKS-1:0] bank_rdy_o,
  output logic [PW-1:0]        fill_ptr_o,
  output logic [PW-1:0]        drain_ptr_o,
  output logic [BW-1:0]        busy_o
);
  ep_dir_e              dir;
  logic                 ep_en_q, ovf_q;
  logic                 auto_eff, fill_free, fill_room, drain_rdy;
  logic                 wr_ok, rd_ok, eob_hit, fill_last, rd_last;
  logic                 commit, release_b, req_raw;
  logic [NUM_BANKS-1:0] rdy;
  logic [PW-1:0]        fill_ptr, drain_ptr;
  logic [CW-1:0]        fill_cnt, drain_cnt, rd_idx;

  assign dir = ep_dir_e'(dir_in_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ep_en_q <= (EP_INDEX == 0);
    else if (en_wr_i) ep_en_q <= en_val_i;
  end

  // control endpoints never auto-validate
  assign auto_eff  = auto_val_i & ~ctrl_type_i;
  assign fill_free = ~rdy[fill_ptr];
  assign fill_room = fill_cnt < CW'(BANK_BYTES);
  assign drain_rdy = rdy[drain_ptr];

  assign wr_ok     = ep_en_q & wr_en_i & fill_free & fill_room;
  assign rd_ok     = ep_en_q & rd_en_i & drain_rdy & (rd_idx < drain_cnt);
  assign eob_hit   = ep_en_q & dma_eob_i & eob_en_i & auto_eff;
  assign fill_last = wr_ok & (fill_cnt == CW'(BANK_BYTES - 1));
  assign rd_last   = rd_ok & (rd_idx == drain_cnt - 1'b1);

  always_comb begin
    commit    = 1'b0;
    release_b = 1'b0;
    if (ep_en_q) begin
      if (dir == DIR_IN) begin
        commit    = fill_free & (sw_commit_i | (auto_eff & fill_last) | eob_hit);
        release_b = drain_rdy & bus_done_i;
      end else begin
        commit    = fill_free & wr_end_i;
        release_b = drain_rdy & (sw_release_i | (auto_eff & rd_last) | eob_hit);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= ep_en_q & wr_en_i & ~wr_ok;
  end

  ep_bank_store #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_BYTES(BANK_BYTES),
    .DATA_W    (DATA_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ok_i    (wr_ok),
    .wr_bank_i  (fill_ptr),
    .wr_data_i  (wr_data_i),
    .rd_ok_i    (rd_ok),
    .rel_i      (release_b),
    .rd_bank_i  (drain_ptr),
    .fill_cnt_o (fill_cnt),
    .drain_cnt_o(drain_cnt),
    .rd_idx_o   (rd_idx),
    .rd_data_o  (rd_data_o)
  );

  ep_bank_flags #(
    .NUM_BANKS(NUM_BANKS)
  ) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .release_i  (release_b),
    .rdy_o      (rdy),
    .fill_ptr_o (fill_ptr),
    .drain_ptr_o(drain_ptr)
  );

  assign req_raw = ep_en_q & ((dir == DIR_IN) ? fill_free : drain_rdy);

  ep_dma_gate #(
    .NUM_SRC(NUM_SRC)
  ) u_gate (
    .req_raw_i(req_raw),
    .intdis_i (intdis_dma_i),
    .src_i    (irq_src_i),
    .en_i     (irq_en_i),
    .req_o    (dma_req_o)
  );

  assign ep_en_o     = ep_en_q;
  assign ovf_o       = ovf_q;
  assign bank_rdy_o  = rdy;
  assign fill_ptr_o  = fill_ptr;
  assign drain_ptr_o = drain_ptr;
  assign rd_len_o    = drain_cnt;
  assign rd_rdy_o    = drain_rdy;
  assign busy_o      = BW'($countones(rdy));
endmodule

// File: rtl/ep_bank_ctrl_chk.sv
module ep_bank_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int NUM_SRC   = 4,
  localparam int PW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BW = $clog2(NUM_BANKS + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic                 ovf_o,
  input logic                 intdis_dma_i,
  input logic [NUM_SRC-1:0]   irq_src_i,
  input logic [NUM_SRC-1:0]   irq_en_i,
  input logic                 dma_req_o,
  input logic                 ep_en_o,
  input logic [NUM_BANKS-1:0] bank_rdy_o,
  input logic [PW-1:0]        fill_ptr_o,
  input logic [PW-1:0]        drain_ptr_o,
  input logic [BW-1:0]        busy_o
);
  // R10
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(wr_en_i));

  // R9
  dma_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intdis_dma_i && |(irq_src_i & irq_en_i)) |-> !dma_req_o);

  // R12
  dis_no_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ep_en_o |-> !dma_req_o);

  // R11
  fill_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_ptr_o != $past(fill_ptr_o)) |-> bank_rdy_o[$past(fill_ptr_o)]);

  // R11
  drain_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_ptr_o != $past(drain_ptr_o)) |-> !bank_rdy_o[$past(drain_ptr_o)]);

  // R11
  busy_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(busy_o) <= int'($past(busy_o)) + 1) && (int'(busy_o) + 1 >= int'($past(busy_o))));
endmodule

bind ep_bank_ctrl ep_bank_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS),
  .NUM_SRC  (NUM_SRC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .ovf_o       (ovf_o),
  .intdis_dma_i(intdis_dma_i),
  .irq_src_i   (irq_src_i),
  .irq_en_i    (irq_en_i),
  .dma_req_o   (dma_req_o),
  .ep_en_o     (ep_en_o),
  .bank_rdy_o  (bank_rdy_o),
  .fill_ptr_o  (fill_ptr_o),
  .drain_ptr_o (drain_ptr_o),
  .busy_o      (busy_o)
);

// File: tb/ep_bank_ctrl_test.sv
module ep_bank_ctrl_test;
  localparam int NB = 2;
  localparam int BB = 4;
  localparam int NS = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_wr_i, en_val_i, dir_in_i, ctrl_type_i, auto_val_i, eob_en_i, intdis_dma_i;
  logic wr_en_i, wr_end_i, sw_commit_i, sw_release_i, rd_en_i, bus_done_i, dma_eob_i;
  logic [7:0]    wr_data_i, rd_data_o;
  logic [2:0]    rd_len_o;
  logic [NS-1:0] irq_src_i, irq_en_i;
  logic [NB-1:0] bank_rdy_o;
  logic [1:0]    busy_o;
  logic          fill_ptr_o, drain_ptr_o;
  logic          ep_en_o, rd_rdy_o, dma_req_o, ovf_o;
  logic          ep1_en, ep1_rdy_dummy, ep1_dma, ep1_ovf, ep1_fp, ep1_dp;
  logic [7:0]    ep1_data;
  logic [2:0]    ep1_len;
  logic [NB-1:0] ep1_rdy;
  logic [1:0]    ep1_busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  ep_bank_ctrl #(.NUM_BANKS(NB), .BANK_BYTES(BB), .NUM_SRC(NS), .EP_INDEX(0)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_wr_i(en_wr_i), .en_val_i(en_val_i), .ep_en_o(ep_en_o),
    .dir_in_i(dir_in_i), .ctrl_type_i(ctrl_type_i), .auto_val_i(auto_val_i), .eob_en_i(eob_en_i),
    .intdis_dma_i(intdis_dma_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .wr_end_i(wr_end_i),
    .sw_commit_i(sw_commit_i), .sw_release_i(sw_release_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .rd_len_o(rd_len_o), .rd_rdy_o(rd_rdy_o), .bus_done_i(bus_done_i),
    .dma_eob_i(dma_eob_i), .irq_src_i(irq_src_i), .irq_en_i(irq_en_i), .dma_req_o(dma_req_o),
    .ovf_o(ovf_o), .bank_rdy_o(bank_rdy_o), .fill_ptr_o(fill_ptr_o), .drain_ptr_o(drain_ptr_o),
    .busy_o(busy_o));

  ep_bank_ctrl #(.NUM_BANKS(NB), .BANK_BYTES(BB), .NUM_SRC(NS), .EP_INDEX(1)) uut_ep1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_wr_i(1'b0), .en_val_i(1'b0), .ep_en_o(ep1_en),
    .dir_in_i(1'b1), .ctrl_type_i(1'b0), .auto_val_i(1'b0), .eob_en_i(1'b0),
    .intdis_dma_i(1'b0), .wr_en_i(1'b0), .wr_data_i(8'h00), .wr_end_i(1'b0),
    .sw_commit_i(1'b0), .sw_release_i(1'b0), .rd_en_i(1'b0),
    .rd_data_o(ep1_data), .rd_len_o(ep1_len), .rd_rdy_o(ep1_rdy_dummy), .bus_done_i(1'b0),
    .dma_eob_i(1'b0), .irq_src_i('0), .irq_en_i('0), .dma_req_o(ep1_dma),
    .ovf_o(ep1_ovf), .bank_rdy_o(ep1_rdy), .fill_ptr_o(ep1_fp), .drain_ptr_o(ep1_dp),
    .busy_o(ep1_busy));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic clear_strobes();
    en_wr_i = 0; wr_en_i = 0; wr_end_i = 0; sw_commit_i = 0; sw_release_i = 0;
    rd_en_i = 0; bus_done_i = 0; dma_eob_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    clear_strobes();
    en_val_i = 0; dir_in_i = 1; ctrl_type_i = 0; auto_val_i = 0; eob_en_i = 0;
    intdis_dma_i = 0; irq_src_i = '0; irq_en_i = '0; wr_data_i = '0;
    cyc();
    rst_ni = 1;
    cyc();
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1; wr_data_i = d; cyc(); wr_en_i = 0;
  endtask
  task automatic rd();        rd_en_i = 1;      cyc(); rd_en_i = 0;      endtask
  task automatic commit_sw(); sw_commit_i = 1;  cyc(); sw_commit_i = 0;  endtask
  task automatic release_sw();sw_release_i = 1; cyc(); sw_release_i = 0; endtask
  task automatic bus_done();  bus_done_i = 1;   cyc(); bus_done_i = 0;   endtask
  task automatic eob();       dma_eob_i = 1;    cyc(); dma_eob_i = 0;    endtask
  task automatic pkt_end();   wr_end_i = 1;     cyc(); wr_end_i = 0;     endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 rdy", bank_rdy_o, 0);
    chk("R1 fill", fill_ptr_o, 0);
    chk("R1 drain", drain_ptr_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 ep0 en", ep_en_o, 1);
    chk("R1 ep1 en", ep1_en, 0);
    chk("R1 ep1 dma", ep1_dma, 0);
  endtask

  task automatic t_in_full();
    do_reset();
    auto_val_i = 1;
    wr(8'h11); wr(8'h22); wr(8'h33);
    chk("R2 not full", bank_rdy_o, 0);
    wr(8'h44);
    chk("R2 rdy", bank_rdy_o, 1);
    chk("R2 fill", fill_ptr_o, 1);
    chk("R2 len", rd_len_o, 4);
    chk("R2 d0", rd_data_o, 8'h11); rd();
    chk("R2 d1", rd_data_o, 8'h22); rd();
    chk("R2 d2", rd_data_o, 8'h33); rd();
    chk("R2 d3", rd_data_o, 8'h44); rd();
    bus_done();
    chk("R2 busy", busy_o, 0);
    chk("R11 drain", drain_ptr_o, 1);
  endtask

  task automatic t_in_eob();
    do_reset();
    auto_val_i = 1;
    wr(8'h01); wr(8'h02);
    eob();
    chk("R3 no eob_en", bank_rdy_o, 0);
    eob_en_i = 1;
    eob();
    chk("R3 rdy", bank_rdy_o, 1);
    chk("R3 len", rd_len_o, 2);
  endtask

  task automatic t_sw_commit();
    do_reset();
    wr(8'h9C);
    commit_sw();
    chk("R4 rdy", bank_rdy_o, 1);
    chk("R4 len", rd_len_o, 1);
    chk("R4 data", rd_data_o, 8'h9C);
    commit_sw();
    chk("R4 zlp rdy", bank_rdy_o, 3);
    chk("R11 busy2", busy_o, 2);
    bus_done();
    chk("R4 zlp len", rd_len_o, 0);
    chk("R4 zlp drain", drain_ptr_o, 1);
  endtask

  task automatic t_out_last();
    do_reset();
    dir_in_i = 0; auto_val_i = 1;
    wr(8'hA1); wr(8'hA2); wr(8'hA3);
    chk("R5 before end", rd_rdy_o, 0);
    pkt_end();
    chk("R5 rdy", rd_rdy_o, 1);
    chk("R5 len", rd_len_o, 3);
    rd(); rd();
    chk("R5 held", rd_rdy_o, 1);
    chk("R5 d2", rd_data_o, 8'hA3);
    rd();
    chk("R5 released", rd_rdy_o, 0);
    chk("R5 drain", drain_ptr_o, 1);
    chk("R5 busy", busy_o, 0);
  endtask

  task automatic t_out_eob();
    do_reset();
    dir_in_i = 0; auto_val_i = 1; eob_en_i = 1;
    wr(8'h10); wr(8'h20); wr(8'h30); pkt_end();
    rd();
    eob();
    chk("R6 busy", busy_o, 0);
    chk("R6 drain", drain_ptr_o, 1);
  endtask

  task automatic t_sw_release();
    do_reset();
    dir_in_i = 0;
    wr(8'hAA); wr(8'hBB); pkt_end();
    wr(8'hCC); pkt_end();
    chk("R7 busy2", busy_o, 2);
    rd();
    chk("R7 d1", rd_data_o, 8'hBB);
    release_sw();
    chk("R7 drain", drain_ptr_o, 1);
    chk("R7 next len", rd_len_o, 1);
    chk("R7 next data", rd_data_o, 8'hCC);
    chk("R7 busy1", busy_o, 1);
    rd();
    chk("R7 no auto hold", rd_rdy_o, 1);
  endtask

  task automatic t_ctrl();
    do_reset();
    ctrl_type_i = 1; auto_val_i = 1; eob_en_i = 1;
    wr(8'h01); wr(8'h02); wr(8'h03); wr(8'h04);
    chk("R8 full no commit", bank_rdy_o, 0);
    eob();
    chk("R8 eob no commit", bank_rdy_o, 0);
    wr(8'h05);
    chk("R10 full ovf", ovf_o, 1);
    cyc();
    chk("R10 ovf pulse", ovf_o, 0);
    commit_sw();
    chk("R10 len kept", rd_len_o, 4);
    chk("R10 d0 kept", rd_data_o, 8'h01);
  endtask

  task automatic t_dma();
    do_reset();
    #1 chk("R9 base", dma_req_o, 1);
    intdis_dma_i = 1; irq_src_i = 2'b01; irq_en_i = 2'b00;
    #1 chk("R9 src disabled", dma_req_o, 1);
    irq_en_i = 2'b01;
    #1 chk("R9 masked", dma_req_o, 0);
    intdis_dma_i = 0;
    #1 chk("R9 intdis off", dma_req_o, 1);
    intdis_dma_i = 1; irq_src_i = 2'b00;
    #1 chk("R9 src cleared", dma_req_o, 1);
    cyc();
    dir_in_i = 0;
    #1 chk("R9 out empty", dma_req_o, 0);
  endtask

  task automatic t_ovf_rr();
    do_reset();
    wr(8'h5A); commit_sw();
    wr(8'h6B); commit_sw();
    chk("R11 fill wrap", fill_ptr_o, 0);
    chk("R11 busy", busy_o, 2);
    wr(8'h7C);
    chk("R10 ovf", ovf_o, 1);
    chk("R10 busy", busy_o, 2);
    cyc();
    chk("R10 pulse", ovf_o, 0);
    chk("R10 b0 data", rd_data_o, 8'h5A);
    chk("R10 b0 len", rd_len_o, 1);
    bus_done();
    chk("R10 b1 data", rd_data_o, 8'h6B);
    chk("R11 busy1", busy_o, 1);
    commit_sw();
    chk("R11 fill next", fill_ptr_o, 1);
    chk("R11 busy again", busy_o, 2);
  endtask

  task automatic t_disable();
    do_reset();
    en_wr_i = 1; en_val_i = 0; cyc(); en_wr_i = 0;
    chk("R12 en off", ep_en_o, 0);
    #1 chk("R12 dma off", dma_req_o, 0);
    wr(8'hEE);
    chk("R12 no ovf", ovf_o, 0);
    commit_sw();
    chk("R12 no commit", busy_o, 0);
    en_wr_i = 1; en_val_i = 1; cyc(); en_wr_i = 0;
    chk("R12 en on", ep_en_o, 1);
    commit_sw();
    chk("R12 nothing stored", rd_len_o, 0);
    chk("R12 committed", busy_o, 1);
  endtask

  initial begin
    clear_strobes();
    en_val_i = 0; dir_in_i = 1; ctrl_type_i = 0; auto_val_i = 0; eob_en_i = 0;
    intdis_dma_i = 0; irq_src_i = '0; irq_en_i = '0; wr_data_i = '0;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_in_full();
    t_in_eob();
    t_sw_commit();
    t_out_last();
    t_out_eob();
    t_sw_release();
    t_ctrl();
    t_dma();
    t_ovf_rr();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule